// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block holds the program counter of a 32-bit RISC core whose instructions are all four bytes long, and decides each cycle where execution goes next. The decode stage presents a control-flow kind, a comparison selector, the two source operands, the two saved return addresses, a 26-bit immediate field and a destination register index. From these the unit forms the next PC. For the kinds that save a return point, it also forms a register write-back of the address after the current instruction.

The PC is a register inside the unit and is visible on `pc_q`. The next value is visible on `next_pc` in the same cycle and is loaded at the rising clock edge. An external redirect request, such as an exception entry, overrides every instruction-driven target and cancels the link write-back of the instruction it interrupts.

Top module: `pc_next_unit`

## Requirements
- R1: When `rst_n` is low at a rising edge, `pc_q` takes the parameter `RESET_VEC` (default 32'h0000_0100), whatever the other inputs are.
- R2: For `cf_kind` 0 (no control flow) and for the unused codes 10 to 15, `next_pc` is `pc_q + 4` and `link_we` is low.
- R3: For `cf_kind` 1 (absolute jump), `next_pc` is `{pc_q[31:28], imm_field[25:0], 2'b00}`.
- R4: For `cf_kind` 2 (absolute call), `next_pc` is the same as in R3. `link_we` is high, with `link_idx` 31 and `link_data` equal to `pc_q + 4`.
- R5: For `cf_kind` 3 (unconditional relative branch), `next_pc` is `pc_q + 4 + (sign-extended imm_field[15:0] with bits 1:0 forced to 0)`.
- R6: For `cf_kind` 4 (conditional branch), the unit compares `opnd_a` with `opnd_b` using the code on `cmp_sel`: 0 signed A>=B, 1 signed A<B, 2 A!=B, 3 A==B, 4 unsigned A>=B, 5 unsigned A<B. Codes 6 and 7 are never taken. A taken branch goes to the R5 target and a branch that is not taken goes to `pc_q + 4`.
- R7: `cf_kind` 5 (register jump) sets `next_pc` to `opnd_a`. `cf_kind` 6 (register call) does the same and also writes `pc_q + 4` to register 31.
- R8: `cf_kind` 7 (return) sets `next_pc` to `ret_addr`. `cf_kind` 8 (breakpoint return) sets `next_pc` to `brk_ret_addr`.
- R9: For `cf_kind` 9 (read next PC), `next_pc` is `pc_q + 4` and `link_data` is `pc_q + 4` with `link_idx` equal to `dest_c`. `link_we` is high only when `dest_c` is not 0.
- R10: When `redirect_req` is high, `next_pc` is `redirect_vec` and `link_we` is low, whatever the kind is.
- R11: `next_pc` is combinational from the current inputs and `pc_q`, and `pc_q` takes `next_pc` at every rising edge outside reset. The link outputs are combinational in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cf_kind | input | 4 | Control-flow kind of the current instruction |
| cmp_sel | input | 3 | Comparison code for conditional branches |
| opnd_a | input | 32 | Register A value: compare operand and indirect target |
| opnd_b | input | 32 | Register B value: compare operand |
| ret_addr | input | 32 | Contents of register 31 |
| brk_ret_addr | input | 32 | Contents of register 30 |
| imm_field | input | 26 | Immediate: word index for jumps, low 16 bits as branch offset |
| dest_c | input | 5 | Destination register index for read-next-PC |
| redirect_req | input | 1 | External redirect request |
| redirect_vec | input | 32 | Target of the redirect |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | PC to be loaded at the next edge |
| link_we | output | 1 | Link write-back enable |
| link_idx | output | 5 | Link write-back register index |
| link_data | output | 32 | Link write-back value |

## Verification
The redirect request can fall in the same cycle as an instruction that saves a return address: an absolute call, a register call, or a read of the next PC with a non-zero destination. The random stimulus raises the redirect in about one cycle in eight, independent of the kind, so it lands on every kind. Directed cycles also pair it with a call. In each collision the PC must take the redirect vector and no link write may appear. Reset against a pending jump is provoked in the same way.

// File: rtl/bnp_pkg.sv
// Shared encodings for the branch and next-PC unit.
// Assumes the decode stage drives these codes unchanged.
package bnp_pkg;

    typedef enum logic [3:0] {
        CF_NONE   = 4'd0,
        CF_JABS   = 4'd1,
        CF_CABS   = 4'd2,
        CF_BRU    = 4'd3,
        CF_BRC    = 4'd4,
        CF_JREG   = 4'd5,
        CF_CREG   = 4'd6,
        CF_RET    = 4'd7,
        CF_BRET   = 4'd8,
        CF_NEXTPC = 4'd9
    } cf_kind_e;

    typedef enum logic [2:0] {
        CMP_GE   = 3'd0,
        CMP_LT   = 3'd1,
        CMP_NE   = 3'd2,
        CMP_EQ   = 3'd3,
        CMP_GEU  = 3'd4,
        CMP_LTU  = 3'd5,
        CMP_RSV6 = 3'd6,
        CMP_RSV7 = 3'd7
    } cmp_sel_e;

endpackage

// File: rtl/bnp_cond_eval.sv
// Branch condition evaluator.
// Compares two operands under one of six relations and reports the outcome.
// Assumes reserved selector codes must never take the branch.
module bnp_cond_eval
    import bnp_pkg::*;
#(
    parameter int W = 32
) (
    input  cmp_sel_e       sel,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           take
);

    logic eq_w;
    logic lts_w;
    logic ltu_w;

    // Share one equality and two ordering results across all relations.
    always_comb begin
        eq_w  = (a == b);
        lts_w = ($signed(a) < $signed(b));
        ltu_w = (a < b);
    end

    // Pick the relation named by the selector.
    always_comb begin
        case (sel)
            CMP_GE:  take = !lts_w;
            CMP_LT:  take = lts_w;
            CMP_NE:  take = !eq_w;
            CMP_EQ:  take = eq_w;
            CMP_GEU: take = !ltu_w;
            CMP_LTU: take = ltu_w;
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/bnp_target_gen.sv
// Candidate target generator.
// Forms the sequential, absolute-segment and PC-relative targets from the
// current PC and the immediate field.
// Assumes 4-byte instructions and an offset field narrower than the index field.
module bnp_target_gen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 26,
    parameter int OFS_W  = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [IDX_W-1:0]  imm,
    output logic [ADDR_W-1:0] seq_tgt,
    output logic [ADDR_W-1:0] abs_tgt,
    output logic [ADDR_W-1:0] rel_tgt
);

    localparam int SEG_W  = ADDR_W - IDX_W - 2;
    localparam int EXT_W  = ADDR_W - OFS_W;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

    logic [ADDR_W-1:0] ofs_ext;

    // Address of the following instruction.
    always_comb seq_tgt = pc + STEP;

    // Keep the current segment and splice in the word index.
    generate
        if (SEG_W > 0) begin : g_seg
            always_comb abs_tgt = {pc[ADDR_W-1 -: SEG_W], imm, 2'b00};
        end else begin : g_noseg
            always_comb abs_tgt = {imm[ADDR_W-3:0], 2'b00};
        end
    endgenerate

    // Sign-extend the offset, force word alignment, add to the sequential PC.
    always_comb begin
        ofs_ext = {{EXT_W{imm[OFS_W-1]}}, imm[OFS_W-1:0]} & WORD_MASK;
        rel_tgt = seq_tgt + ofs_ext;
    end

endmodule

// File: rtl/bnp_link_ctl.sv
// Link write-back control.
// Decides whether the instruction saves a return point and in which register.
// Assumes register 0 is hard-wired to zero, so writes to it are dropped.
module bnp_link_ctl
    import bnp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int RIDX_W = 5
) (
    input  cf_kind_e          kind,
    input  logic [RIDX_W-1:0] dest_c,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] seq_tgt,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [ADDR_W-1:0] link_data
);

    localparam logic [RIDX_W-1:0] LINK_REG = {RIDX_W{1'b1}};

    logic want_w;

    // Classify kinds that save a return point and pick the register.
    always_comb begin
        want_w   = 1'b0;
        link_idx = LINK_REG;
        case (kind)
            CF_CABS, CF_CREG: want_w = 1'b1;
            CF_NEXTPC: begin
                want_w   = (dest_c != '0);
                link_idx = dest_c;
            end
            default: want_w = 1'b0;
        endcase
    end

    // A redirect cancels the interrupted instruction's write-back.
    always_comb begin
        link_we   = want_w && !redirect;
        link_data = seq_tgt;
    end

endmodule

// File: rtl/pc_next_unit.sv
// Branch and next-PC unit: top level.
// Holds the program counter, selects the next PC with a redirect taking
// precedence over every instruction target, and emits the link write-back.
// Assumes the inputs are stable and valid for the whole cycle.
module pc_next_unit
    import bnp_pkg::*;
#(
    parameter int                 ADDR_W    = 32,
    parameter int                 IDX_W     = 26,
    parameter int                 OFS_W     = 16,
    parameter int                 RIDX_W    = 5,
    parameter logic [ADDR_W-1:0]  RESET_VEC = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cf_kind,
    input  logic [2:0]        cmp_sel,
    input  logic [ADDR_W-1:0] opnd_a,
    input  logic [ADDR_W-1:0] opnd_b,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [ADDR_W-1:0] brk_ret_addr,
    input  logic [IDX_W-1:0]  imm_field,
    input  logic [RIDX_W-1:0] dest_c,
    input  logic              redirect_req,
    input  logic [ADDR_W-1:0] redirect_vec,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] next_pc,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [ADDR_W-1:0] link_data
);

    cf_kind_e          kind_w;
    cmp_sel_e          sel_w;
    logic              take_w;
    logic [ADDR_W-1:0] seq_w;
    logic [ADDR_W-1:0] abs_w;
    logic [ADDR_W-1:0] rel_w;
    logic [ADDR_W-1:0] insn_tgt_w;

    // Map raw codes onto the shared encodings.
    always_comb begin
        kind_w = cf_kind_e'(cf_kind);
        sel_w  = cmp_sel_e'(cmp_sel);
    end

    bnp_cond_eval #(.W(ADDR_W)) u_cond (
        .sel  (sel_w),
        .a    (opnd_a),
        .b    (opnd_b),
        .take (take_w)
    );

    bnp_target_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_tgt (
        .pc      (pc_q),
        .imm     (imm_field),
        .seq_tgt (seq_w),
        .abs_tgt (abs_w),
        .rel_tgt (rel_w)
    );

    bnp_link_ctl #(.ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) u_link (
        .kind      (kind_w),
        .dest_c    (dest_c),
        .redirect  (redirect_req),
        .seq_tgt   (seq_w),
        .link_we   (link_we),
        .link_idx  (link_idx),
        .link_data (link_data)
    );

    // Target implied by the instruction alone.
    always_comb begin
        case (kind_w)
            CF_JABS, CF_CABS: insn_tgt_w = abs_w;
            CF_BRU:           insn_tgt_w = rel_w;
            CF_BRC:           insn_tgt_w = take_w ? rel_w : seq_w;
            CF_JREG, CF_CREG: insn_tgt_w = opnd_a;
            CF_RET:           insn_tgt_w = ret_addr;
            CF_BRET:          insn_tgt_w = brk_ret_addr;
            default:          insn_tgt_w = seq_w;
        endcase
    end

    // The redirect request overrides any instruction target.
    always_comb next_pc = redirect_req ? redirect_vec : insn_tgt_w;

    // Program counter register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_VEC;
        else        pc_q <= next_pc;
    end

endmodule

// File: rtl/bnp_checker.sv
// Property checker for the branch and next-PC unit, bound to the top level.
// Observes ports only.
module bnp_checker #(
    parameter int                ADDR_W    = 32,
    parameter int                RIDX_W    = 5,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_0100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cf_kind,
    input logic [RIDX_W-1:0] dest_c,
    input logic              redirect_req,
    input logic [ADDR_W-1:0] redirect_vec,
    input logic [ADDR_W-1:0] pc_q,
    input logic              link_we,
    input logic [RIDX_W-1:0] link_idx,
    input logic [ADDR_W-1:0] link_data
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    // R1: reset loads the reset vector.
    a_r1_reset_vec: assert property (@(posedge clk)
        !rst_n |=> pc_q == RESET_VEC);

    // R2: with no control flow, the PC advances by one instruction.
    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_req && (cf_kind == 4'd0 || cf_kind >= 4'd10))
        |=> pc_q == $past(pc_q) + STEP);

    // R2: with no control flow, there is no link write.
    a_r2_no_link: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_kind == 4'd0) |-> !link_we);

    // R4: an absolute call links into register 31.
    a_r4_call_link: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_kind == 4'd2 && !redirect_req)
        |-> (link_we && link_idx == {RIDX_W{1'b1}} && link_data == pc_q + STEP));

    // R9: a read of the next PC into register 0 is dropped.
    a_r9_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_kind == 4'd9 && dest_c == '0) |-> !link_we);

    // R10: a redirect wins and cancels the link write.
    a_r10_redirect_pc: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_req |=> pc_q == $past(redirect_vec));

    a_r10_redirect_nolink: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_req |-> !link_we);

endmodule

bind pc_next_unit bnp_checker #(
    .ADDR_W    (ADDR_W),
    .RIDX_W    (RIDX_W),
    .RESET_VEC (RESET_VEC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cf_kind      (cf_kind),
    .dest_c       (dest_c),
    .redirect_req (redirect_req),
    .redirect_vec (redirect_vec),
    .pc_q         (pc_q),
    .link_we      (link_we),
    .link_idx     (link_idx),
    .link_data    (link_data)
);

// File: tb/sim_pc_next_unit.sv
module sim_pc_next_unit;

    localparam logic [31:0] RST_V = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cf_kind = '0;
    logic [2:0]  cmp_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] ret_addr = '0;
    logic [31:0] brk_ret_addr = '0;
    logic [25:0] imm_field = '0;
    logic [4:0]  dest_c = '0;
    logic        redirect_req = 1'b0;
    logic [31:0] redirect_vec = '0;
    logic [31:0] pc_q;
    logic [31:0] next_pc;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] exp_pc;

    pc_next_unit u0 (
        .clk(clk), .rst_n(rst_n), .cf_kind(cf_kind), .cmp_sel(cmp_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .ret_addr(ret_addr),
        .brk_ret_addr(brk_ret_addr), .imm_field(imm_field), .dest_c(dest_c),
        .redirect_req(redirect_req), .redirect_vec(redirect_vec),
        .pc_q(pc_q), .next_pc(next_pc), .link_we(link_we),
        .link_idx(link_idx), .link_data(link_data)
    );

    always #10 clk = ~clk;

    function automatic bit cond_ok(input logic [2:0] s, input logic [31:0] a, input logic [31:0] b);
        case (s)
            3'd0: return $signed(a) >= $signed(b);
            3'd1: return $signed(a) <  $signed(b);
            3'd2: return a != b;
            3'd3: return a == b;
            3'd4: return a >= b;
            3'd5: return a <  b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] model_next(input logic [31:0] pc);
        logic [31:0] seq;
        logic [31:0] rel;
        seq = pc + 32'd4;
        rel = seq + ({{16{imm_field[15]}}, imm_field[15:0]} & 32'hFFFF_FFFC);
        if (redirect_req) return redirect_vec;
        case (cf_kind)
            4'd1, 4'd2: return {pc[31:28], imm_field, 2'b00};
            4'd3:       return rel;
            4'd4:       return cond_ok(cmp_sel, opnd_a, opnd_b) ? rel : seq;
            4'd5, 4'd6: return opnd_a;
            4'd7:       return ret_addr;
            4'd8:       return brk_ret_addr;
            default:    return seq;
        endcase
    endfunction

    function automatic string tag_of();
        if (redirect_req) return "R10";
        case (cf_kind)
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5, 4'd6: return "R7";
            4'd7, 4'd8: return "R8";
            4'd9: return "R9";
            default: return "R2";
        endcase
    endfunction

    task automatic check32(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Inputs are already set (driven after a negedge); check comb outputs, then the register.
    task automatic step();
        logic        ewe;
        logic [4:0]  eidx;
        logic [31:0] enx;
        string       t;
        #1;
        t    = tag_of();
        enx  = model_next(exp_pc);
        ewe  = !redirect_req && (cf_kind == 4'd2 || cf_kind == 4'd6 ||
                                 (cf_kind == 4'd9 && dest_c != 5'd0));
        eidx = (cf_kind == 4'd9) ? dest_c : 5'd31;
        check32(t, "next_pc", next_pc, enx);
        check32(t, "link_we", {31'd0, link_we}, {31'd0, ewe});
        if (ewe) begin
            check32(t, "link_idx", {27'd0, link_idx}, {27'd0, eidx});
            check32(t, "link_data", link_data, exp_pc + 32'd4);
        end
        @(posedge clk);
        #1;
        exp_pc = enx;
        check32("R11", "pc_q", pc_q, exp_pc);
        @(negedge clk);
    endtask

    task automatic set_op(input logic [3:0] k, input logic [2:0] s, input logic [31:0] a,
                          input logic [31:0] b, input logic [25:0] im, input logic [4:0] dc,
                          input logic rq, input logic [31:0] rv);
        cf_kind = k; cmp_sel = s; opnd_a = a; opnd_b = b; imm_field = im;
        dest_c = dc; redirect_req = rq; redirect_vec = rv;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7251));
        ret_addr = 32'h0000_4440;
        brk_ret_addr = 32'h0000_7770;
        set_op(4'd1, 3'd0, 0, 0, 26'h3ff_ffff, 5'd0, 1'b1, 32'hDEAD_0000);
        repeat (3) @(posedge clk);
        #1;
        check32("R1", "pc_q after reset", pc_q, RST_V);
        @(negedge clk);
        rst_n = 1'b1;
        exp_pc = RST_V;

        // R2 plain step and unused kind code
        set_op(4'd0, 3'd0, 0, 0, 0, 5'd3, 1'b0, 0); step();
        set_op(4'd13, 3'd0, 0, 0, 0, 5'd3, 1'b0, 0); step();
        // R3: move into a high segment, then an absolute jump keeps bits 31:28
        set_op(4'd0, 3'd0, 0, 0, 0, 5'd0, 1'b1, 32'hA000_0010); step();
        set_op(4'd1, 3'd0, 0, 0, 26'h123_4567, 5'd0, 1'b0, 0); step();
        // R4 absolute call
        set_op(4'd2, 3'd0, 0, 0, 26'h000_0040, 5'd0, 1'b0, 0); step();
        // R5 negative offset with low bits set
        set_op(4'd3, 3'd0, 0, 0, 26'h000_FFF7, 5'd0, 1'b0, 0); step();
        // R6 signed and unsigned disagree: A=-1, B=1
        set_op(4'd4, 3'd1, 32'hFFFF_FFFF, 32'd1, 26'h20, 5'd0, 1'b0, 0); step();
        set_op(4'd4, 3'd5, 32'hFFFF_FFFF, 32'd1, 26'h20, 5'd0, 1'b0, 0); step();
        set_op(4'd4, 3'd3, 32'h55, 32'h55, 26'h13, 5'd0, 1'b0, 0); step();
        set_op(4'd4, 3'd6, 32'h55, 32'h55, 26'h40, 5'd0, 1'b0, 0); step();
        // R7 register jump and call
        set_op(4'd5, 3'd0, 32'h0000_9000, 0, 0, 5'd0, 1'b0, 0); step();
        set_op(4'd6, 3'd0, 32'h0000_A000, 0, 0, 5'd0, 1'b0, 0); step();
        // R8 return and breakpoint return
        set_op(4'd7, 3'd0, 0, 0, 0, 5'd0, 1'b0, 0); step();
        set_op(4'd8, 3'd0, 0, 0, 0, 5'd0, 1'b0, 0); step();
        // R9 read next PC: normal and into register 0
        set_op(4'd9, 3'd0, 0, 0, 0, 5'd12, 1'b0, 0); step();
        set_op(4'd9, 3'd0, 0, 0, 0, 5'd0, 1'b0, 0); step();
        // R10 redirect collides with a call and a register call
        set_op(4'd2, 3'd0, 0, 0, 26'h55, 5'd0, 1'b1, 32'h0000_0C00); step();
        set_op(4'd6, 3'd0, 32'h1234, 0, 0, 5'd0, 1'b1, 32'h0000_0D00); step();

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra;
            ra = $urandom;
            ret_addr = $urandom & 32'hFFFF_FFFC;
            brk_ret_addr = $urandom & 32'hFFFF_FFFC;
            set_op(4'($urandom_range(0, 15)), 3'($urandom), ra,
                   ($urandom_range(0, 3) == 0) ? ra : $urandom,
                   26'($urandom), 5'($urandom_range(0, 3) == 0 ? 0 : $urandom),
                   ($urandom_range(0, 7) == 0), $urandom & 32'hFFFF_FFFC);
            step();
        end

        // R1 reset wins over a pending jump
        set_op(4'd5, 3'd0, 32'h0000_5550, 0, 0, 5'd0, 1'b0, 0);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check32("R1", "pc_q reset over jump", pc_q, RST_V);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule